// File: doc/BRIEF.md
# Recursive Split Binary Decoder

This block turns an n-bit binary code into a 2^n-bit one-hot vector. It does not use a single flat AND-plane. It splits the input into an upper field and a lower field and decodes each field with a smaller copy of itself. It then forms every output line as the AND of one upper line and one lower line. A one-bit code ends the recursion: that case needs only an inverter.

A parameter chooses where the input is split. In chain mode the lower field keeps all bits except the top one, so the logic depth grows linearly with the width. In balanced mode the lower field takes half the bits, rounded down, so the depth grows with the logarithm of the width. Each line from a sub-decoder then drives 2^(n/2) gates of the parent AND array. The block is purely combinational. Buffering for fanout and timing closure are left to the surrounding flow.

Top module: `rsplit_decoder`

## Requirements
- R1: With WIDTH = 1, output bit 1 equals the input bit and output bit 0 equals its complement.
- R2: For every input code, exactly one output bit is 1.
- R3: The output bit that is 1 sits at the index equal to the unsigned binary value of the input (bit 0 for all-zeros, bit 2^WIDTH−1 for all-ones).
- R4: BALANCED = 0 (chain split, lower field WIDTH−1 bits) and BALANCED = 1 (balanced split, lower field floor(WIDTH/2) bits) produce identical outputs for every input code.
- R5: R2 and R3 hold for every WIDTH from 1 to 8 in both split modes.
- R6: The output depends only on the present input, with no clock or storage: a new input code is reflected at the output without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel | input | WIDTH | Binary code to decode |
| onehot | output | 2^WIDTH | One-hot decoded lines, bit i high when sel = i |

## Verification
The bound checker evaluates every instance at every level of the recursion whenever its inputs change. At each change it checks that exactly one line is active, that the active line matches the code, and that the lowest and highest lines behave correctly. Equivalence of the two split modes and coverage of every width from 1 to 8 can only be shown by the bench's scenarios. The same holds for the one-bit terminal case and for settling without a clock. The bench sweeps all codes on side-by-side instances of both modes.

// File: rtl/rsplit_decoder.sv
module rsplit_decoder #(
  parameter int WIDTH    = 8,
  parameter bit BALANCED = 1'b1
) (
  input  logic [WIDTH-1:0]        sel,
  output logic [(1<<WIDTH)-1:0]   onehot
);
  localparam int LO_W = (WIDTH == 1) ? 1 : (BALANCED ? WIDTH / 2 : WIDTH - 1);
  localparam int HI_W = (WIDTH == 1) ? 1 : WIDTH - LO_W;

  generate
    if (WIDTH == 1) begin : g_leaf
      assign onehot = {sel[0], ~sel[0]};
    end else begin : g_split
      logic [(1<<HI_W)-1:0] hi_lines;
      logic [(1<<LO_W)-1:0] lo_lines;

      rsplit_decoder #(.WIDTH(HI_W), .BALANCED(BALANCED)) u_hi (
        .sel    (sel[WIDTH-1:LO_W]),
        .onehot (hi_lines)
      );

      rsplit_decoder #(.WIDTH(LO_W), .BALANCED(BALANCED)) u_lo (
        .sel    (sel[LO_W-1:0]),
        .onehot (lo_lines)
      );

      for (genvar q = 0; q < (1 << HI_W); q++) begin : g_row
        for (genvar r = 0; r < (1 << LO_W); r++) begin : g_col
          assign onehot[q*(1<<LO_W)+r] = hi_lines[q] & lo_lines[r];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/rsplit_decoder_chk.sv
module rsplit_decoder_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0]      sel,
  input logic [(1<<WIDTH)-1:0] onehot
);
  always_comb begin
    if (!$isunknown(sel) && !$isunknown(onehot)) begin
      p_single_line_r2: assert ($countones(onehot) == 1);
      p_line_at_code_r3: assert (onehot[sel] == 1'b1);
      p_bottom_line_r3: assert (onehot[0] == (sel == '0));
      p_top_line_r3: assert (onehot[(1<<WIDTH)-1] == (&sel));
    end
  end
endmodule

bind rsplit_decoder rsplit_decoder_chk #(.WIDTH(WIDTH)) u_chk (
  .sel    (sel),
  .onehot (onehot)
);

// File: tb/test_rsplit_decoder.sv
module test_rsplit_decoder;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [7:0]   main_sel;
  logic [255:0] main_out;

  rsplit_decoder #(.WIDTH(8), .BALANCED(1'b1)) i_rsplit_decoder (
    .sel    (main_sel),
    .onehot (main_out)
  );

  logic [7:0]   dsel [2][8];
  logic [255:0] dout [2][8];

  for (genvar m = 0; m < 2; m++) begin : g_mode
    for (genvar g = 0; g < 8; g++) begin : g_w
      logic [(1<<(g+1))-1:0] o;
      rsplit_decoder #(.WIDTH(g + 1), .BALANCED(m == 1)) i_dec (
        .sel    (dsel[m][g][g:0]),
        .onehot (o)
      );
      assign dout[m][g] = 256'(o);
    end
  end

  function automatic logic [255:0] ref_line(input int code);
    logic [255:0] v = '0;
    v[code] = 1'b1;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset_state;
    main_sel = '0;
    @(negedge clk);
    check(main_out == ref_line(0), "R3 code zero", main_out, ref_line(0));
  endtask

  task automatic t_width_one;
    for (int b = 0; b < 2; b++) begin
      dsel[0][0] = 8'(b);
      dsel[1][0] = 8'(b);
      #5;
      check(dout[0][0] == 256'({1'(b), ~1'(b)}), "R1 chain leaf", dout[0][0], 256'({1'(b), ~1'(b)}));
      check(dout[1][0] == 256'({1'(b), ~1'(b)}), "R1 balanced leaf", dout[1][0], 256'({1'(b), ~1'(b)}));
    end
  endtask

  task automatic t_sweep_all;
    for (int m = 0; m < 2; m++) begin
      for (int g = 0; g < 8; g++) begin
        for (int c = 0; c < (1 << (g + 1)); c++) begin
          dsel[m][g] = 8'(c);
          #2;
          check($countones(dout[m][g]) == 1, "R2 R5 single line", dout[m][g], ref_line(c));
          check(dout[m][g] == ref_line(c), "R3 R5 index", dout[m][g], ref_line(c));
        end
      end
    end
  endtask

  task automatic t_mode_match;
    for (int g = 0; g < 8; g++) begin
      for (int c = 0; c < (1 << (g + 1)); c++) begin
        dsel[0][g] = 8'(c);
        dsel[1][g] = 8'(c);
        #2;
        check(dout[0][g] == dout[1][g], "R4 modes agree", dout[1][g], dout[0][g]);
      end
    end
  endtask

  task automatic t_no_clock;
    @(posedge clk);
    #2;
    main_sel = 8'hA5;
    #3;
    check(main_out == ref_line(8'hA5), "R6 settles between edges", main_out, ref_line(8'hA5));
    main_sel = 8'hFF;
    #3;
    check(main_out == ref_line(255), "R6 R3 all ones", main_out, ref_line(255));
    main_sel = 8'h01;
    #3;
    check(main_out == ref_line(1), "R6 R3 code one", main_out, ref_line(1));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 2; m++)
      for (int g = 0; g < 8; g++)
        dsel[m][g] = '0;
    t_reset_state();
    t_width_one();
    t_sweep_all();
    t_mode_match();
    t_no_clock();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule